// File: doc/BRIEF.md
# Two-Stage Cascaded Clock Divider with Bypass and Duty Correction

This block divides an input clock by the product of two programmable stage ratios. Each stage counts a high phase and a low phase. Both lengths come from 4-bit fields that hold the cycle count minus one, so a single stage divides by anything from 2 to 32. Two stages in series reach up to 1024. Only ratios that factor into two stage ratios are reachable.

Each stage has its own bypass bit. Bypassing both stages passes the input clock through unchanged. Bypassing only the second stage gives a single-stage divider. A single-stage setup must use the first stage. Bypassing the first stage while the second is in use is illegal: the block runs as fully bypassed and raises an error flag.

Duty-cycle correction is on unless the disable bit is set. With correction on, each stage aims for a 50% high phase. An odd first-stage ratio uses the falling edge of the input clock to add the missing half cycle. An odd second-stage ratio adds the extra half as half a first-stage period. A synchronous sync pulse clears both stage counters together, which fixes the output phase.

The block carries no data stream, so it has no valid/ready handshake. All pins are plain control or clock pins.

Top module: `cdiv_cascade`

## Requirements
- R1: A stage divides by low+high+2 input cycles. The low and high fields are 4-bit values holding the cycle count minus one, so a stage ratio lies between 2 and 32.
- R2: With s1_byp_i=0 and s2_byp_i=1, one rising-to-rising period of clk_o equals the first-stage ratio in clk_i cycles.
- R3: With both bypass bits 0, the clk_o period equals the product of the two stage ratios (up to 1024). The second-stage counter advances only when the first stage wraps.
- R4: With both bypass bits 1, clk_o follows clk_i (ratio 1) and the second-stage counter is held at zero.
- R5: The combination s1_byp_i=1 and s2_byp_i=0 drives cfg_err_o to 1 and behaves exactly as both stages bypassed. Every other combination gives cfg_err_o=0.
- R6: With dcc_off_i=1, the output is high for (high field+1) cycles of the last active stage's input and then low. For a single stage this is (high+1) clk_i cycles. In cascade it is (high2+1) times the first-stage ratio, in clk_i cycles.
- R7: With dcc_off_i=0, a lone first stage of ratio D is high for D/2 clk_i cycles. For odd D this ends on a falling clk_i edge, for example 1.5 cycles for D=3.
- R8: With dcc_off_i=0 in cascade, clk_o is high for floor(D2/2) first-stage periods. For odd D2 it also stays high for the first floor(D1/2) clk_i cycles of the next first-stage period.
- R9: A sync_i pulse sampled at a clk_i rising edge clears both counters, even when the first stage is wrapping in that cycle. The next clk_o rising edge then comes exactly D1·D2 (or D1) clk_i cycles after that edge.
- R10: While rst_ni is low, both counters are zero, so clk_o is high in either divided mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Synchronous counter clear for phase alignment |
| s1_low_i | input | 4 | First stage low cycles minus one |
| s1_high_i | input | 4 | First stage high cycles minus one |
| s2_low_i | input | 4 | Second stage low cycles minus one |
| s2_high_i | input | 4 | Second stage high cycles minus one |
| s1_byp_i | input | 1 | Bypass first stage |
| s2_byp_i | input | 1 | Bypass second stage |
| dcc_off_i | input | 1 | Disable duty-cycle correction |
| clk_o | output | 1 | Divided clock |
| cfg_err_o | output | 1 | Illegal bypass combination selected |

## Verification
A sync pulse and a first-stage wrap can fall in the same clk_i cycle. In that cycle the wrap would advance the second stage, while the sync must clear both counters. The bench provokes this by waiting for a rising edge of clk_o, then counting D1−1 more input edges before raising sync_i. Sync is therefore sampled while the first counter sits on its last value. The result is judged by the time from that sampling edge to the next clk_o rise, which must equal the full product ratio, and by the periods that follow.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
  // Operating mode decoded from the two bypass bits
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,   // input clock passes straight through
    MODE_ONE  = 2'd1,   // first stage only
    MODE_TWO  = 2'd2    // both stages in series
  } cdiv_mode_e;
endpackage

// File: rtl/cdiv_counter.sv
`timescale 1ns/1ps
module cdiv_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  // >= so that a shrunk ratio recovers on the next advance
  assign wrap_o = adv_i && (cnt_o >= last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clr_i)   cnt_o <= '0;
    else if (adv_i)   cnt_o <= wrap_o ? '0 : cnt_o + 1'b1;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && cnt_o >= last_i) |=> (cnt_o == '0)); // R1
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0)); // R9
endmodule

// File: rtl/cdiv_mode.sv
`timescale 1ns/1ps
module cdiv_mode
  import cdiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       s1_byp_i,
  input  logic       s2_byp_i,
  input  logic       lvl1_i,
  input  logic       lvl2_i,
  output cdiv_mode_e mode_o,
  output logic       cfg_err_o,
  output logic       clk_o
);
  always_comb begin
    cfg_err_o = s1_byp_i && !s2_byp_i;
    if (s1_byp_i)      mode_o = MODE_PASS;  // illegal combo folds into pass
    else if (s2_byp_i) mode_o = MODE_ONE;
    else               mode_o = MODE_TWO;
  end

  always_comb begin
    case (mode_o)
      MODE_PASS: clk_o = clk_i;
      MODE_ONE:  clk_o = lvl1_i;
      default:   clk_o = lvl2_i;
    endcase
  end
endmodule

// File: rtl/cdiv_cascade.sv
`timescale 1ns/1ps
module cdiv_cascade
  import cdiv_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic [FIELD_W-1:0] s1_low_i,
  input  logic [FIELD_W-1:0] s1_high_i,
  input  logic [FIELD_W-1:0] s2_low_i,
  input  logic [FIELD_W-1:0] s2_high_i,
  input  logic               s1_byp_i,
  input  logic               s2_byp_i,
  input  logic               dcc_off_i,
  output logic               clk_o,
  output logic               cfg_err_o
);
  localparam int CNT_W   = FIELD_W + 2;
  localparam int NSTAGE  = 2;

  cdiv_mode_e       mode;
  logic             dcc_on;
  logic [FIELD_W-1:0] low_v  [NSTAGE];
  logic [FIELD_W-1:0] high_v [NSTAGE];
  logic [CNT_W-1:0] cnt    [NSTAGE];
  logic [CNT_W-1:0] ratio  [NSTAGE];
  logic [CNT_W-1:0] hcnt   [NSTAGE];
  logic [NSTAGE-1:0] byp_eff, adv, clr, wrap, lvl;

  assign dcc_on    = !dcc_off_i;
  assign low_v[0]  = s1_low_i;
  assign high_v[0] = s1_high_i;
  assign low_v[1]  = s2_low_i;
  assign high_v[1] = s2_high_i;
  assign byp_eff[0] = (mode == MODE_PASS);
  assign byp_eff[1] = (mode != MODE_TWO);

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    logic [CNT_W-1:0] half;
    logic             base;

    assign ratio[g] = CNT_W'(low_v[g]) + CNT_W'(high_v[g]) + CNT_W'(2);
    assign hcnt[g]  = CNT_W'(high_v[g]) + CNT_W'(1);
    assign half     = ratio[g] >> 1;
    assign clr[g]   = sync_i || byp_eff[g];
    assign base     = dcc_on ? (cnt[g] < half) : (cnt[g] < hcnt[g]);

    if (g == 0) begin : g_first
      logic neg_q;
      assign adv[g] = 1'b1;
      // half-cycle stretch taken from the falling input edge
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) neg_q <= 1'b0;
        else         neg_q <= base;
      end
      assign lvl[g] = base || (dcc_on && ratio[g][0] && neg_q);
    end else begin : g_later
      logic [CNT_W-1:0] prev_half;
      assign prev_half = ratio[g-1] >> 1;
      assign adv[g]    = wrap[g-1];
      // stretch by half a period of the previous stage
      assign lvl[g] = base || (dcc_on && ratio[g][0] && (cnt[g] == half)
                               && (cnt[g-1] < prev_half));
    end

    cdiv_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr[g]),
      .adv_i  (adv[g]),
      .last_i (ratio[g] - CNT_W'(1)),
      .cnt_o  (cnt[g]),
      .wrap_o (wrap[g])
    );
  end

  cdiv_mode u_mode (
    .clk_i     (clk_i),
    .s1_byp_i  (s1_byp_i),
    .s2_byp_i  (s2_byp_i),
    .lvl1_i    (lvl[0]),
    .lvl2_i    (lvl[1]),
    .mode_o    (mode),
    .cfg_err_o (cfg_err_o),
    .clk_o     (clk_o)
  );

  AST_STAGE2_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && !byp_eff[1] && !wrap[0]) |=> $stable(cnt[1])); // R3
  AST_BYPASS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_byp_i || s2_byp_i) |=> (cnt[1] == '0)); // R4
  AST_ERR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> (cnt[0] == '0)); // R5
endmodule

// File: tb/cdiv_cascade_bench.sv
`timescale 1ns/1ps
module cdiv_cascade_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync = 1'b0;
  logic [3:0] l1 = 4'd1, h1 = 4'd0, l2 = 4'd0, h2 = 4'd0;
  logic       b1 = 1'b0, b2 = 1'b1, doff = 1'b0;
  logic       dclk, err;

  int  n_chk = 0, n_err = 0;
  longint per_q[$];
  longint exp_hi = 0;
  longint last_t = 0;
  bit     armed = 1'b0;
  string  tag = "";

  always #5 clk = ~clk;

  cdiv_cascade u_cdiv_cascade (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync),
    .s1_low_i(l1), .s1_high_i(h1), .s2_low_i(l2), .s2_high_i(h2),
    .s1_byp_i(b1), .s2_byp_i(b2), .dcc_off_i(doff),
    .clk_o(dclk), .cfg_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: period between rising edges, popped from scoreboard queue
  always @(posedge dclk) begin
    if (armed && per_q.size() > 0) begin
      longint p, e;
      p = longint'($time) - last_t;
      e = per_q.pop_front();
      chk(p == e, tag, "period ns", p, e);
      last_t = longint'($time);
    end
  end

  // monitor: high time after each rise
  always @(negedge dclk) begin
    if (armed && exp_hi != 0 && per_q.size() > 0) begin
      longint hgt;
      hgt = longint'($time) - last_t;
      chk(hgt == exp_hi, tag, "high ns", hgt, exp_hi);
    end
  end

  // driver: configure, sync, push expected periods
  task automatic run_case(input string t, input int m1, input int n1,
                          input int m2, input int n2, input bit by1,
                          input bit by2, input bit off, input int ratio,
                          input int hi_ns, input bit align, input int d1);
    armed = 1'b0;
    @(negedge clk);
    l1 = 4'(m1); h1 = 4'(n1); l2 = 4'(m2); h2 = 4'(n2);
    b1 = by1; b2 = by2; doff = off;
    if (align) begin
      // land the sync on the cycle where stage one wraps
      @(posedge dclk);
      repeat (d1 - 1) @(posedge clk);
      @(negedge clk);
    end
    tag = t;
    sync = 1'b1;
    @(posedge clk);
    last_t = longint'($time);
    @(negedge clk);
    sync = 1'b0;
    exp_hi = hi_ns;
    for (int i = 0; i < 3; i++) per_q.push_back(longint'(ratio) * 10);
    armed = 1'b1;
    for (int c = 0; c < ratio * 4 + 50 && per_q.size() > 0; c++) @(posedge clk);
    if (per_q.size() > 0) begin
      chk(1'b0, t, "periods missing", per_q.size(), 0);
      per_q.delete();
    end
    armed = 1'b0;
  endtask

  initial begin
    #3_000_000;
    chk(1'b0, "watchdog", "run hung", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dclk == 1'b1, "R10", "clk_o in reset", dclk, 1);
    chk(err == 1'b0, "R10", "cfg_err in reset", err, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R7: single stage ratio 3, corrected duty 15 ns
    run_case("R2", 1, 0, 0, 0, 0, 1, 0, 3, 15, 0, 3);
    chk(err == 1'b0, "R5", "cfg_err legal", err, 0);
    // R1: single stage at max 32, even so half = 160 ns
    run_case("R1", 15, 15, 0, 0, 0, 1, 0, 32, 160, 0, 32);
    // R6: single stage ratio 7, duty from high field: 2 cycles
    run_case("R6", 4, 1, 0, 0, 0, 1, 1, 7, 20, 0, 7);
    // R8 R3: 3 x 5, high = 2*3 + 1 cycles
    run_case("R8", 1, 0, 2, 1, 0, 0, 0, 15, 70, 0, 3);
    // R6 R3: 2 x 4 uncorrected, high = 1 * 2 cycles
    run_case("R6", 0, 0, 2, 0, 0, 0, 1, 8, 20, 0, 2);
    // R3: 32 x 32 = 1024
    run_case("R3", 15, 15, 15, 15, 0, 0, 0, 1024, 5120, 0, 32);
    // R4: full bypass passes the input clock
    run_case("R4", 3, 3, 3, 3, 1, 1, 0, 1, 5, 0, 1);
    chk(err == 1'b0, "R4", "cfg_err full bypass", err, 0);
    // R5: illegal combination
    run_case("R5", 2, 2, 2, 2, 1, 0, 0, 1, 5, 0, 1);
    chk(err == 1'b1, "R5", "cfg_err illegal", err, 1);
    // R9: 4 x 3 with sync on the wrap cycle, high = 4 + 2 cycles
    run_case("R3", 1, 1, 1, 0, 0, 0, 0, 12, 60, 0, 4);
    run_case("R9", 1, 1, 1, 0, 0, 0, 0, 12, 60, 1, 4);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule